// File: doc/BRIEF.md
# RF Serial Write Controller

This block sends configuration words to an external RF synthesizer over a three-wire, transmit-only serial link (clock, data, latch enable). Software sets the transfer length through a count register, loads the low sixteen bits of the word, and then writes the upper bits. That last write launches the transfer. The word is shifted out MSB first. Only the low N bits are sent, where N is the programmed length. A single latch-enable pulse follows the last bit. Typical words are 24 bits long, for example 0x00C007.

The count register takes a requested length value. Bits 6:0 of that value become the bit count. Bit 7 of the value is kept as a separate flag, which reads back at bit 8 and drives an output pin. A status bit reports that a transfer is running. While a transfer runs, the block refuses all register writes.

Top module: `rf_serial_writer`

## Requirements
- R1: A write to address 0 stores wr_data[6:0] as the bit count and wr_data[7] as the flag. Reading address 0 returns the count in bits 6:0 and the flag in bit 8, with all other bits 0. The flag also drives rf_flag.
- R2: Address 1 holds bits 15:0 of the outgoing word. Address 2 holds the bits above 15. Both read back what was written, with unused upper bits read as 0.
- R3: When the block is idle and the count is nonzero, a write to address 2 sets busy on the next clock. Bit 0 of address 3 reads 1 while busy.
- R4: The low N bits of {high, low} are sent MSB first. Each bit occupies one serial period of 2*HALF_DIV clocks. rf_sclk is low for the first half and high for the second, and rf_sdata holds steady while rf_sclk is high.
- R5: With a count of 0, a write to address 2 stores the value but starts no transfer.
- R6: A count above WORD_W sends WORD_W bits.
- R7: After the last bit, rf_le is high for one serial period while rf_sclk stays low, and then busy clears. Busy lasts exactly (N+1)*2*HALF_DIV clocks. When idle, rf_sclk, rf_sdata and rf_le are 0.
- R8: While busy, writes to addresses 0, 1 and 2 are ignored. The registers and the transfer in flight are unchanged.
- R9: After reset, busy, rf_sclk, rf_sdata, rf_le and rf_flag are 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 low, 2 high, 3 status) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| rf_flag | output | 1 | Flag bit held in the count register |
| rf_sclk | output | 1 | Serial clock to the synthesizer |
| rf_sdata | output | 1 | Serial data, MSB first |
| rf_le | output | 1 | Latch-enable strobe after the last bit |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check several properties on every cycle:
- an accepted launch with a nonzero length raises busy, and a zero length does not;
- the latch strobe never overlaps a high serial clock;
- data is stable across the high phase;
- busy falls only right after the latch strobe;
- the line is quiet while idle.

Some behaviours only the bench scenarios can show: that the right bits arrive in the right order, the clamping of long counts, the packing of the count register on readback, and that writes made mid-transfer leave both the registers and the shifted word untouched.

// File: rtl/rfw_pkg.sv
package rfw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_LATCH = 2'd2
   } rfw_state_t;

   localparam logic [1:0] RA_COUNT  = 2'd0;
   localparam logic [1:0] RA_LOW    = 2'd1;
   localparam logic [1:0] RA_HIGH   = 2'd2;
   localparam logic [1:0] RA_STATUS = 2'd3;

   localparam int CNT_W = 7;
endpackage

// File: rtl/rfw_regs.sv
module rfw_regs
   import rfw_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int HI_W  = WORD_W - 16,
   localparam int LEN_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [1:0]        rd_addr,
   input  logic              busy,
   output logic [15:0]       rd_data,
   output logic              start,
   output logic [WORD_W-1:0] word,
   output logic [LEN_W-1:0]  len,
   output logic              flag
);
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic [15:0]      lo_q;
   logic [HI_W-1:0]  hi_q;
   logic [15:0]      hi_rd;
   logic             accept;

   assign accept = wr_en && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else if (accept) begin
         case (wr_addr)
            RA_COUNT: begin
               cnt_q  <= wr_data[CNT_W-1:0];
               flag_q <= wr_data[CNT_W];
            end
            RA_LOW:  lo_q <= wr_data;
            RA_HIGH: hi_q <= wr_data[HI_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      if (cnt_q > CNT_W'(WORD_W)) len = LEN_W'(WORD_W);
      else                        len = LEN_W'(cnt_q);
   end

   assign start = accept && (wr_addr == RA_HIGH) && (cnt_q != '0);
   assign word  = {wr_data[HI_W-1:0], lo_q};
   assign flag  = flag_q;

   generate
      if (HI_W == 16) begin : g_hi_full
         assign hi_rd = hi_q;
      end else begin : g_hi_ext
         assign hi_rd = {{(16-HI_W){1'b0}}, hi_q};
      end
   endgenerate

   always_comb begin
      case (rd_addr)
         RA_COUNT: rd_data = {7'd0, flag_q, 1'b0, cnt_q};
         RA_LOW:   rd_data = lo_q;
         RA_HIGH:  rd_data = hi_rd;
         default:  rd_data = {15'd0, busy};
      endcase
   end
endmodule

// File: rtl/rfw_shifter.sv
module rfw_shifter
   import rfw_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int HALF_DIV = 2,
   localparam int LEN_W   = $clog2(WORD_W + 1),
   localparam int IDX_W   = $clog2(WORD_W),
   localparam int DIV_W   = $clog2(2 * HALF_DIV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic [LEN_W-1:0]  len,
   output logic              busy,
   output logic              sclk,
   output logic              sdata,
   output logic              le
);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(2 * HALF_DIV - 1);
   localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(HALF_DIV);

   rfw_state_t        state_q;
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DIV_W-1:0]  div_q;
   logic              div_end;

   assign div_end = (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         word_q  <= '0;
         idx_q   <= '0;
         div_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_SHIFT;
                  word_q  <= word;
                  idx_q   <= IDX_W'(len - LEN_W'(1));
                  div_q   <= '0;
               end
            end
            ST_SHIFT: begin
               div_q <= div_end ? '0 : div_q + DIV_W'(1);
               if (div_end) begin
                  if (idx_q == '0) state_q <= ST_LATCH;
                  else             idx_q   <= idx_q - IDX_W'(1);
               end
            end
            ST_LATCH: begin
               div_q <= div_end ? '0 : div_q + DIV_W'(1);
               if (div_end) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state_q != ST_IDLE);
   assign sclk  = (state_q == ST_SHIFT) && (div_q >= DIV_HALF);
   assign sdata = (state_q == ST_SHIFT) && word_q[idx_q];
   assign le    = (state_q == ST_LATCH);
endmodule

// File: rtl/rf_serial_writer.sv
module rf_serial_writer
   import rfw_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [1:0]  rd_addr,
   output logic [15:0] rd_data,
   output logic        rf_flag,
   output logic        rf_sclk,
   output logic        rf_sdata,
   output logic        rf_le,
   output logic        busy
);
   localparam int LEN_W = $clog2(WORD_W + 1);

   generate
      if (WORD_W < 17 || WORD_W > 32) begin : g_bad_width
         $error("WORD_W must lie in 17..32");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
   endgenerate

   logic              start;
   logic [WORD_W-1:0] word;
   logic [LEN_W-1:0]  xfer_len;

   rfw_regs #(.WORD_W(WORD_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .busy    (busy),
      .rd_data (rd_data),
      .start   (start),
      .word    (word),
      .len     (xfer_len),
      .flag    (rf_flag)
   );

   rfw_shifter #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .word  (word),
      .len   (xfer_len),
      .busy  (busy),
      .sclk  (rf_sclk),
      .sdata (rf_sdata),
      .le    (rf_le)
   );
endmodule

// File: rtl/rf_serial_writer_chk.sv
module rf_serial_writer_chk #(
   parameter int LEN_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             busy,
   input logic             rf_sclk,
   input logic             rf_sdata,
   input logic             rf_le,
   input logic [LEN_W-1:0] xfer_len
);
   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && !busy && xfer_len != '0) |=> busy);

   assert_zero_len_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && !busy && xfer_len == '0) |=> !busy);

   assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_sclk && $past(rf_sclk)) |-> $stable(rf_sdata));

   assert_le_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_le |-> !rf_sclk);

   assert_busy_after_le_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(rf_le));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rf_sclk && !rf_sdata && !rf_le));
endmodule

bind rf_serial_writer rf_serial_writer_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/rf_serial_writer_bench.sv
module rf_serial_writer_bench;
   localparam int WORD_W   = 32;
   localparam int HALF_DIV = 2;
   localparam int PER      = 2 * HALF_DIV;
   localparam int NVEC     = 8;

   // {count write value, low half, high half}
   localparam logic [47:0] VEC [NVEC] = '{
      {16'h0018, 16'hC007, 16'h0000},
      {16'h0018, 16'h9C03, 16'h0012},
      {16'h0098, 16'h1728, 16'h0014},
      {16'h0008, 16'h00A5, 16'hFFFF},
      {16'h0001, 16'h0001, 16'h0000},
      {16'h0020, 16'h5A5A, 16'hA5A5},
      {16'h0028, 16'h1234, 16'h8765},
      {16'h007F, 16'hBEEF, 16'hC0DE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        rf_flag, rf_sclk, rf_sdata, rf_le, busy;

   int checks = 0;
   int errors = 0;

   logic [63:0] rx;
   int nbits, bcyc, lecyc;
   logic [15:0] stat_mid;

   always #2 clk = ~clk;

   rf_serial_writer #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_rf_serial_writer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .rf_flag(rf_flag), .rf_sclk(rf_sclk),
      .rf_sdata(rf_sdata), .rf_le(rf_le), .busy(busy)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic run(input logic [15:0] c, input logic [15:0] lo, input logic [15:0] hi,
                      input bit poke);
      logic prev;
      int guard;
      wr(2'd0, c); wr(2'd1, lo); wr(2'd2, hi);
      rx = '0; nbits = 0; bcyc = 0; lecyc = 0; prev = 1'b0; guard = 0;
      stat_mid = '0;
      while (busy && guard < 2000) begin
         bcyc++;
         if (rf_sclk && !prev) begin
            rx = {rx[62:0], rf_sdata};
            nbits++;
         end
         if (rf_le) lecyc++;
         prev = rf_sclk;
         if (bcyc == 2) rd(2'd3, stat_mid);
         if (poke && bcyc >= 3 && bcyc <= 5) begin
            wr_en = 1'b1; wr_addr = 2'(bcyc - 3); wr_data = 16'hFFFF;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
         guard++;
      end
      wr_en = 1'b0;
   endtask

   function automatic int exp_len(input logic [15:0] c);
      int n = int'(c[6:0]);
      return (n > WORD_W) ? WORD_W : n;
   endfunction

   initial begin
      repeat (2000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 busy", 64'(busy), 0);
      chk("R9 lines", 64'({rf_sclk, rf_sdata, rf_le, rf_flag}), 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk("R9 reg", 64'(d), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // Table-driven transfers: R1 R2 R3 R4 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         logic [15:0] c, lo, hi;
         logic [31:0] w;
         int n;
         logic [63:0] mask;
         {c, lo, hi} = VEC[i];
         n = exp_len(c);
         w = {hi, lo};
         mask = (64'd1 << n) - 64'd1;
         run(c, lo, hi, 1'b0);
         chk("R4 bit count", 64'(nbits), 64'(n));
         chk("R4 bits MSB first", rx & mask, 64'(w) & mask);
         chk("R7 busy length", 64'(bcyc), 64'((n + 1) * PER));
         chk("R7 latch length", 64'(lecyc), 64'(PER));
         chk("R3 status bit", 64'(stat_mid), 1);
         chk("R1 flag pin", 64'(rf_flag), 64'(c[7]));
         rd(2'd0, d);
         chk("R1 count readback", 64'(d), 64'({7'd0, c[7], 1'b0, c[6:0]}));
         rd(2'd1, d);
         chk("R2 low readback", 64'(d), 64'(lo));
         rd(2'd2, d);
         chk("R2 high readback", 64'(d), 64'(hi));
         rd(2'd3, d);
         chk("R3 status idle", 64'(d), 0);
      end

      // R5: zero count starts nothing
      wr(2'd0, 16'h0000); wr(2'd1, 16'h1111); wr(2'd2, 16'h2222);
      begin
         int seen = 0;
         for (int k = 0; k < 12; k++) begin
            if (busy || rf_sclk || rf_le) seen++;
            @(negedge clk);
         end
         chk("R5 no transfer", 64'(seen), 0);
      end
      rd(2'd2, d);
      chk("R5 high stored", 64'(d), 64'h2222);

      // R8: writes during busy ignored
      run(16'h0018, 16'h9C03, 16'h0012, 1'b1);
      chk("R8 bits unchanged", rx & 64'hFF_FFFF, 64'h129C03);
      chk("R8 busy length", 64'(bcyc), 64'(25 * PER));
      rd(2'd0, d);
      chk("R8 count kept", 64'(d), 64'h0018);
      rd(2'd1, d);
      chk("R8 low kept", 64'(d), 64'h9C03);
      rd(2'd2, d);
      chk("R8 high kept", 64'(d), 64'h0012);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule